// File: doc/BRIEF.md
# Bus Error Interrupt Status Controller

This block collects four bus-error event sources (system error, parity error, master abort and target abort) into a single debug interrupt line. Each source has a sticky status flag that is set by a single-cycle event pulse. Each source also has a mask bit that gates its contribution to the interrupt, and a write-only clear bit that resets its flag.

Software sees one 32-bit register at a fixed address. A read returns the flags, the masks and zeros elsewhere. A write updates the mask field and applies any clear bits in the same cycle. Every source starts masked after reset, so the interrupt stays quiet until software unmasks the sources it wants.

Top module: `buserr_irq_ctl`

## Requirements
- R1: After reset, a read at the register address returns 0x00000F00 (all flags 0, all masks 1) and `irq` is low.
- R2: Event input bit 3 is system error, bit 2 parity error, bit 1 master abort and bit 0 target abort. A pulse on an event bit sets the flag at the same position of register bits 3:0, and the flag reads 1 from the cycle after the pulse.
- R3: A status flag stays set until software clears it, however many cycles pass.
- R4: Register bits 11:8 are the masks, in the same source order (1 = masked). A write stores `reg_wdata[11:8]`, and the stored masks read back unchanged.
- R5: Register bits 19:16 are clear bits, in the same source order. Writing 1 resets the matching flag. Writing 0 leaves that flag as it was.
- R6: When an event pulse and a clear of the same source fall in the same cycle, the flag ends up set.
- R7: Clear bits and all unassigned bits (31:20, 15:12, 7:4) always read 0. Writes to the flag field 3:0 have no effect on the flags.
- R8: `irq` is registered. One cycle after any state, it equals the OR over all sources of (flag AND NOT mask).
- R9: A masked source still sets its flag, and the flag is visible on readback.
- R10: Writes to any address other than the register address change nothing. Reads at other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W (8) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_pulse | input | 4 | Single-cycle event pulses: [3] system error, [2] parity error, [1] master abort, [0] target abort |
| irq | output | 1 | Registered debug interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register at 0x18. With only four sources, the flag and mask fields together have 256 combinations. The bench drives every combination and checks both the readback and the interrupt level against values it computes arithmetically. It also sweeps all 16 clear patterns over a fully set flag field. Separate checks cover a set and a clear of the same source in one cycle, long-term stickiness, writes aimed at the flag field, and accesses to a neighbouring address.

// File: rtl/buserr_irq_pkg.sv
package buserr_irq_pkg;
  localparam int NSRC     = 4;
  localparam int DATA_W   = 32;
  localparam int STAT_LSB = 0;
  localparam int MASK_LSB = 8;
  localparam int CLR_LSB  = 16;
  localparam logic [NSRC-1:0] MASK_RST = {NSRC{1'b1}};
endpackage

// File: rtl/bei_rst_sync.sv
module bei_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bei_flag_cell.sv
module bei_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  // set dominates clear so an event arriving with a clear is kept
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bei_mask_reg.sv
module bei_mask_reg #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= RST_VAL;
    else if (we_i) mask_q <= d_i;
  end

  assign q_o = mask_q;
endmodule

// File: rtl/bei_irq_reg.sv
module bei_irq_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(stat_i & ~mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/buserr_irq_ctl.sv
module buserr_irq_ctl
  import buserr_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   evt_pulse,
  output logic              irq
);
  logic            rst_n_sync;
  logic            addr_hit;
  logic            wr_hit;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] mask_q;

  bei_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    addr_hit = (reg_addr == REG_OFFSET);
    wr_hit   = reg_wr & addr_hit;
    clr_vec  = wr_hit ? reg_wdata[CLR_LSB +: NSRC] : '0;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    bei_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .set_i  (evt_pulse[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (status_q[g])
    );
  end

  bei_mask_reg #(.W(NSRC), .RST_VAL(MASK_RST)) u_mask (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we_i  (wr_hit),
    .d_i   (reg_wdata[MASK_LSB +: NSRC]),
    .q_o   (mask_q)
  );

  bei_irq_reg #(.W(NSRC)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .stat_i (status_q),
    .mask_i (mask_q),
    .irq_o  (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (addr_hit) begin
      reg_rdata[STAT_LSB +: NSRC] = status_q;
      reg_rdata[MASK_LSB +: NSRC] = mask_q;
    end
  end
endmodule

// File: rtl/buserr_irq_ctl_chk.sv
module buserr_irq_ctl_chk
  import buserr_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              addr_hit,
  input logic [NSRC-1:0]   evt_pulse,
  input logic [NSRC-1:0]   clr_vec,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq,
  input logic [DATA_W-1:0] reg_rdata
);
  assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~evt_pulse) != '0) |=> ((status_q & $past(clr_vec & ~evt_pulse)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & evt_pulse) != '0) |=> ((status_q & $past(clr_vec & evt_pulse)) == $past(clr_vec & evt_pulse)));

  assert_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[31:12] == '0) && (reg_rdata[7:4] == '0));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status_q & ~mask_q))));

  assert_miss_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (reg_rdata == '0));
endmodule

bind buserr_irq_ctl buserr_irq_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .addr_hit  (addr_hit),
  .evt_pulse (evt_pulse),
  .clr_vec   (clr_vec),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .irq       (irq),
  .reg_rdata (reg_rdata)
);

// File: tb/buserr_irq_ctl_bench.sv
module buserr_irq_ctl_bench;
  localparam logic [7:0] OFF   = 8'h18;
  localparam logic [7:0] OTHER = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = OFF;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  evt_pulse = '0;
  logic        irq;
  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  buserr_irq_ctl u_buserr_irq_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_pulse (evt_pulse),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = OFF; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [3:0] p);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = OFF;
  endtask

  function automatic logic [31:0] cfg(input logic [3:0] m, input logic [3:0] c);
    return {12'h0, c, 4'h0, m, 8'h00};
  endfunction

  initial begin
    #(200000 * 4);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(OFF, rv);
    chk("R1 readback", rv, 32'h0000_0F00);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 R4 R8 R9: exhaustive mask x status sweep
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        wr(OFF, cfg(4'(m), 4'hF));
        pulse(4'(s));
        @(negedge clk);
        rd(OFF, rv);
        chk("R2/R4/R9 readback", rv, (32'(m) << 8) | 32'(s));
        chk("R8 irq", {31'h0, irq}, {31'h0, |(4'(s) & ~4'(m))});
      end
    end

    // R5 clear sweep over a fully set flag field
    for (int c = 0; c < 16; c++) begin
      wr(OFF, cfg(4'hF, 4'hF));
      pulse(4'hF);
      wr(OFF, cfg(4'hF, 4'(c)));
      rd(OFF, rv);
      chk("R5 clear", rv, 32'h0000_0F00 | 32'(4'hF & ~4'(c)));
    end

    // R3 sticky over many cycles
    wr(OFF, cfg(4'h0, 4'hF));
    pulse(4'h6);
    repeat (40) @(negedge clk);
    rd(OFF, rv);
    chk("R3 sticky", rv, 32'h0000_0006);
    chk("R3 irq held", {31'h0, irq}, 32'h1);

    // R6 set and clear of the same source in one cycle
    wr(OFF, cfg(4'h0, 4'hF));
    pulse(4'hF);
    evt_pulse = 4'hA;
    reg_addr = OFF; reg_wdata = cfg(4'h0, 4'hF); reg_wr = 1'b1;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(OFF, rv);
    chk("R6 set wins", rv, 32'h0000_000A);

    // R7 writes to flag field and zero fields have no effect
    wr(OFF, cfg(4'h0, 4'hF));
    pulse(4'h5);
    wr(OFF, 32'hFFF0_FFFA);
    rd(OFF, rv);
    chk("R7 flag field write ignored", rv, 32'h0000_0F05);
    wr(OFF, 32'h0000_0000);
    rd(OFF, rv);
    chk("R7 zero write keeps flags", rv, 32'h0000_0005);

    // R10 other address
    wr(OFF, cfg(4'h3, 4'h0));
    wr(OTHER, cfg(4'hC, 4'hF));
    rd(OFF, rv);
    chk("R10 other write ignored", rv, 32'h0000_0305);
    rd(OTHER, rv);
    chk("R10 other read zero", rv, 32'h0);
    @(negedge clk);
    chk("R8 irq masked mix", {31'h0, irq}, 32'h1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule